// File: doc/BRIEF.md
# Serial Programming Loader

This block receives programming records from a host as a stream of raw 8-bit binary bytes over a full-duplex byte channel and stores them in on-chip memory. On the line side the byte stream runs at 9600 baud, 8 data bits, no parity. The line coding is outside this block, which sees only valid/ready byte ports. Each record is six bytes long and carries a 16-bit group address and four data bytes. The address is classified against two parameterised windows: a one-time-programmable (OTP) window, where all four bytes are written, and an EEPROM window, where only the first byte is written. Records that fall outside both windows are consumed and nothing is written.

Three activities overlap. While the loader collects record k+1, it writes record k through a strobe/busy memory port and then reads those four locations back. For every byte it accepts, it returns one byte of record k-1 as it was read back. The host can therefore verify earlier writes without a separate read pass. A mode input and an active-low security input gate entry. With the mode input low, an external blank-check runs first. With the mode input high and security active, the loader stays shut and blinks an error indicator.

Top module: `prog_loader`

## Requirements
- R1: A record is six bytes in this order: address high, address low, then data bytes d0, d1, d2, d3. If the address is aligned (bits [1:0] = 00) and the group lies in the OTP window, d0..d3 are written to address+0..address+3 in that order, one strobe per byte.
- R2: If the address is aligned and the group lies in the EEPROM window, only d0 is written, at the record address. Bytes d1..d3 are still accepted, but nothing is written for them.
- R3: A group whose base address lies in neither window causes no write. All six of its bytes are still accepted and answered.
- R4: If a record address has bits [1:0] not equal to 00, that group is not written. The error output err_align goes high when the record is handed to the writer and stays high until reset.
- R5: Each accepted byte is answered with exactly one transmitted byte. The answer to byte position p (0..5) of record k is byte p of record k-2 in the form {address high, address low, read-back of base+0..base+3}, where base is the address with bits [1:0] cleared. For records 0 and 1 the answers are 0x00.
- R6: When the loader starts, it transmits a two-byte prompt before it accepts any byte. The prompt is the last two read-back bytes it holds, which are 0x00 after reset.
- R7: mem_we is a single-cycle strobe. From the cycle after a strobe, the writer waits until mem_busy is low before it issues the next write or read. Read data is taken from mem_rdata in the cycle after mem_re.
- R8: Bytes 0..4 of the next record are accepted while writes of the current group are still in progress. Only byte 5 waits until the writer is idle.
- R9: With mode_sel low after reset, blank_start pulses for exactly one cycle. Nothing is accepted or transmitted until blank_done is seen high, after which the prompt follows.
- R10: With mode_sel high and sec_n high after reset, the loader starts directly and blank_start never pulses.
- R11: With mode_sel high and sec_n low (security active), rx_ready and tx_valid stay low and err_led toggles every BLINK_DIV cycles. In every other case err_led stays low.
- R12: While tx_valid is high and tx_ready is low, tx_valid and tx_data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Low: run blank check first; high: examine security |
| sec_n | input | 1 | Security bit, active low (0 = locked) |
| blank_start | output | 1 | One-cycle request to start the blank check |
| blank_done | input | 1 | Blank check finished |
| err_led | output | 1 | Blinking error indicator while locked |
| rx_valid | input | 1 | Host byte available |
| rx_data | input | 8 | Host byte |
| rx_ready | output | 1 | Loader accepts a host byte |
| tx_valid | output | 1 | Answer byte available |
| tx_data | output | 8 | Answer byte |
| tx_ready | input | 1 | Line side takes the answer byte |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |
| mem_busy | input | 1 | Memory still programming |
| err_align | output | 1 | Sticky misaligned-record error |

## Verification
The bench builds the loader with an OTP window of 0x0800..0x0FFF, an EEPROM window of 0x0100..0x01FF and BLINK_DIV of 4. All windows sit under 4 KB, so a small memory model covers both windows, the top edge of each window and the addresses just outside them. The short blink divider lets a few dozen cycles in the locked state show several full toggle periods. A memory busy time of 20 cycles makes the writer the slowest stage. This makes bytes of the next record arrive during writes and forces the final-byte stall.

// File: rtl/prog_loader_pkg.sv
package prog_loader_pkg;
  localparam int REC_BYTES = 6;
  localparam int GRP_BYTES = 4;
  localparam int POS_W     = 3;

  typedef logic [REC_BYTES-1:0][7:0] rec_t;
  typedef logic [GRP_BYTES-1:0][7:0] grp_t;

  typedef enum logic [1:0] {RG_NONE, RG_OTP, RG_EE} region_e;
  typedef enum logic [1:0] {EN_START, EN_BLANK, EN_RUN, EN_LOCK} entry_e;
  typedef enum logic [1:0] {RX_OFF, RX_PROMPT, RX_RECV, RX_SEND} rx_e;
  typedef enum logic [2:0] {WR_IDLE, WR_PUT, WR_WAIT, WR_GET, WR_CAP} wr_e;

  function automatic logic in_window(logic [15:0] a, logic [15:0] lo, logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [15:0] group_base(logic [15:0] a);
    return {a[15:2], 2'b00};
  endfunction

  function automatic region_e classify(logic [15:0] a, logic [15:0] otp_lo, logic [15:0] otp_hi,
                                       logic [15:0] ee_lo, logic [15:0] ee_hi);
    if (in_window(a, otp_lo, otp_hi)) return RG_OTP;
    if (in_window(a, ee_lo, ee_hi))   return RG_EE;
    return RG_NONE;
  endfunction

  function automatic logic [2:0] writes_for(region_e r, logic aligned);
    if (!aligned)     return 3'd0;
    if (r == RG_OTP)  return 3'(GRP_BYTES);
    if (r == RG_EE)   return 3'd1;
    return 3'd0;
  endfunction
endpackage

// File: rtl/prog_loader_entry.sv
module prog_loader_entry
  import prog_loader_pkg::*;
#(
  parameter int BLINK_DIV = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sel,
  input  logic sec_n,
  input  logic blank_done,
  output logic blank_start,
  output logic run,
  output logic locked,
  output logic err_led
);
  localparam int CNT_W = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BLINK_DIV - 1);

  entry_e           st;
  logic [CNT_W-1:0] cnt;
  logic             blank_q;
  logic             led_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= EN_START;
      cnt     <= '0;
      blank_q <= 1'b0;
      led_q   <= 1'b0;
    end else begin
      blank_q <= 1'b0;
      case (st)
        EN_START: begin
          if (!mode_sel) begin
            st      <= EN_BLANK;
            blank_q <= 1'b1;
          end else if (!sec_n) begin
            st <= EN_LOCK;
          end else begin
            st <= EN_RUN;
          end
        end
        EN_BLANK: if (blank_done) st <= EN_RUN;
        EN_LOCK: begin
          if (cnt == CNT_END) begin
            cnt   <= '0;
            led_q <= ~led_q;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign blank_start = blank_q;
  assign run         = (st == EN_RUN);
  assign locked      = (st == EN_LOCK);
  assign err_led     = led_q;

  // R9
  blank_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_start |=> !blank_start);

  // R11
  led_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_led |-> locked);
endmodule

// File: rtl/prog_loader_rx.sv
module prog_loader_rx
  import prog_loader_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic       wr_idle,
  input  rec_t       done_rec,
  output logic       job_valid,
  output rec_t       job_rec
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(REC_BYTES - 1);

  rx_e              st;
  logic [POS_W-1:0] pos;
  logic             pcnt;
  rec_t             hold_q;
  rec_t             echo_q;
  logic [7:0]       tx_q;
  logic             accept;

  assign rx_ready  = (st == RX_RECV) && ((pos != LAST_POS) || wr_idle);
  assign accept    = rx_valid && rx_ready;
  assign job_valid = accept && (pos == LAST_POS);
  assign tx_valid  = (st == RX_PROMPT) || (st == RX_SEND);
  assign tx_data   = tx_q;

  always_comb begin
    for (int i = 0; i < REC_BYTES; i++) begin
      job_rec[i] = (i == REC_BYTES - 1) ? rx_data : hold_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_OFF;
      pos    <= '0;
      pcnt   <= 1'b0;
      hold_q <= '0;
      echo_q <= '0;
      tx_q   <= '0;
    end else begin
      case (st)
        RX_OFF: begin
          if (run) begin
            st   <= RX_PROMPT;
            pcnt <= 1'b0;
            tx_q <= echo_q[REC_BYTES-2];
          end
        end
        RX_PROMPT: begin
          if (tx_ready) begin
            if (!pcnt) begin
              pcnt <= 1'b1;
              tx_q <= echo_q[REC_BYTES-1];
            end else begin
              st  <= RX_RECV;
              pos <= '0;
            end
          end
        end
        RX_RECV: begin
          if (accept) begin
            hold_q[pos] <= rx_data;
            tx_q        <= echo_q[pos];
            if (pos == LAST_POS) echo_q <= done_rec;
            st <= RX_SEND;
          end
        end
        RX_SEND: begin
          if (tx_ready) begin
            pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
            st  <= RX_RECV;
          end
        end
        default: st <= RX_OFF;
      endcase
    end
  end

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R5
  answer_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> tx_valid);

  // R5
  one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);
endmodule

// File: rtl/prog_loader_writer.sv
module prog_loader_writer
  import prog_loader_pkg::*;
#(
  parameter logic [15:0] OTP_LO = 16'h4000,
  parameter logic [15:0] OTP_HI = 16'h7DFF,
  parameter logic [15:0] EE_LO  = 16'h0100,
  parameter logic [15:0] EE_HI  = 16'h01FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        job_valid,
  input  rec_t        job_rec,
  output logic        wr_idle,
  output rec_t        done_rec,
  output logic        mem_we,
  output logic        mem_re,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_busy,
  output logic        err_align
);
  wr_e         st;
  logic [15:0] addr_q;
  logic [15:0] base_q;
  grp_t        data_q;
  grp_t        rb_q;
  logic [2:0]  nwr_q;
  logic [1:0]  idx;
  logic        err_q;

  logic [15:0] job_addr;
  logic        job_aligned;
  region_e     job_region;
  logic [2:0]  job_nwr;

  assign job_addr    = {job_rec[0], job_rec[1]};
  assign job_aligned = (job_addr[1:0] == 2'b00);
  assign job_region  = classify(group_base(job_addr), OTP_LO, OTP_HI, EE_LO, EE_HI);
  assign job_nwr     = writes_for(job_region, job_aligned);

  assign wr_idle   = (st == WR_IDLE);
  assign mem_we    = (st == WR_PUT);
  assign mem_re    = (st == WR_GET);
  assign mem_addr  = base_q + 16'(idx);
  assign mem_wdata = data_q[idx];
  assign err_align = err_q;
  assign done_rec  = {rb_q, addr_q[7:0], addr_q[15:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= WR_IDLE;
      addr_q <= '0;
      base_q <= '0;
      data_q <= '0;
      rb_q   <= '0;
      nwr_q  <= '0;
      idx    <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        WR_IDLE: begin
          if (job_valid) begin
            addr_q <= job_addr;
            base_q <= group_base(job_addr);
            data_q <= job_rec[REC_BYTES-1:2];
            nwr_q  <= job_nwr;
            idx    <= '0;
            if (!job_aligned) err_q <= 1'b1;
            st <= (job_nwr != 3'd0) ? WR_PUT : WR_GET;
          end
        end
        WR_PUT: st <= WR_WAIT;
        WR_WAIT: begin
          if (!mem_busy) begin
            if (({1'b0, idx} + 3'd1) == nwr_q) begin
              idx <= '0;
              st  <= WR_GET;
            end else begin
              idx <= idx + 1'b1;
              st  <= WR_PUT;
            end
          end
        end
        WR_GET: st <= WR_CAP;
        WR_CAP: begin
          rb_q[idx] <= mem_rdata;
          if (idx == 2'(GRP_BYTES - 1)) begin
            idx <= '0;
            st  <= WR_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= WR_GET;
          end
        end
        default: st <= WR_IDLE;
      endcase
    end
  end

  // R7
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R3
  we_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (classify(mem_addr, OTP_LO, OTP_HI, EE_LO, EE_HI) != RG_NONE));

  // R2
  ee_first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && classify(mem_addr, OTP_LO, OTP_HI, EE_LO, EE_HI) == RG_EE) |-> (mem_addr[1:0] == 2'b00));

  // R4
  align_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_align |=> err_align);

  // R7
  no_overlap_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

// File: rtl/prog_loader.sv
module prog_loader
  import prog_loader_pkg::*;
#(
  parameter logic [15:0] OTP_LO    = 16'h4000,
  parameter logic [15:0] OTP_HI    = 16'h7DFF,
  parameter logic [15:0] EE_LO     = 16'h0100,
  parameter logic [15:0] EE_HI     = 16'h01FF,
  parameter int          BLINK_DIV = 1000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_sel,
  input  logic        sec_n,
  output logic        blank_start,
  input  logic        blank_done,
  output logic        err_led,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  output logic        mem_we,
  output logic        mem_re,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_busy,
  output logic        err_align
);
  logic run_w;
  logic locked_w;
  logic wr_idle;
  logic job_valid;
  rec_t job_rec;
  rec_t done_rec;

  prog_loader_entry #(.BLINK_DIV(BLINK_DIV)) u_entry (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sec_n(sec_n),
    .blank_done(blank_done), .blank_start(blank_start), .run(run_w),
    .locked(locked_w), .err_led(err_led)
  );

  prog_loader_rx u_rx (
    .clk(clk), .rst_n(rst_n), .run(run_w), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .wr_idle(wr_idle), .done_rec(done_rec), .job_valid(job_valid), .job_rec(job_rec)
  );

  prog_loader_writer #(.OTP_LO(OTP_LO), .OTP_HI(OTP_HI), .EE_LO(EE_LO), .EE_HI(EE_HI)) u_writer (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_rec(job_rec), .wr_idle(wr_idle),
    .done_rec(done_rec), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_busy(mem_busy), .err_align(err_align)
  );

  // R11
  quiet_until_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |-> (!rx_ready && !tx_valid));

  // R11
  lock_no_memory_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_w |-> (!mem_we && !mem_re));
endmodule

// File: tb/prog_loader_bench.sv
`timescale 1ns/1ps
module prog_loader_bench;
  localparam logic [15:0] OTP_LO = 16'h0800;
  localparam logic [15:0] OTP_HI = 16'h0FFF;
  localparam logic [15:0] EE_LO  = 16'h0100;
  localparam logic [15:0] EE_HI  = 16'h01FF;
  localparam int BLINK = 4;
  localparam int NREC  = 10;

  // record layout: {addr[15:0], d0, d1, d2, d3}
  localparam logic [47:0] RECS [NREC] = '{
    48'h0800_11223344,   // OTP bottom edge
    48'h0104_55667788,   // EEPROM
    48'h0FFC_99AABBCC,   // OTP top edge
    48'h0802_DEADBEEF,   // misaligned
    48'h0300_01020304,   // outside
    48'h01FC_C0C1C2C3,   // EEPROM top edge
    48'h00FC_F0F1F2F3,   // just below EEPROM
    48'h0800_A1A2A3A4,   // overwrite OTP group
    48'h0400_00000000,   // flush
    48'h0404_00000000    // flush
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b1, sec_n = 1'b1, blank_done = 1'b0;
  logic blank_start, err_led;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready, tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic mem_we, mem_re, mem_busy, err_align;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic mem_init = 1'b0;
  int busy_len = 20;
  int busy_cnt = 0;

  logic [7:0] bmem [4096];
  logic [7:0] gold [4096];
  logic [47:0] exp_echo [NREC];

  int tests = 0, fails = 0;
  int cyc = 0, wcount = 0, we_busy = 0, overlap = 0, blanks = 0, seen_io = 0;
  int toggles = 0, last_tog = 0, prev_tog = 0;
  logic led_prev = 1'b0;

  always #2 clk = ~clk;

  prog_loader #(.OTP_LO(OTP_LO), .OTP_HI(OTP_HI), .EE_LO(EE_LO), .EE_HI(EE_HI),
                .BLINK_DIV(BLINK)) u_prog_loader (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sec_n(sec_n),
    .blank_start(blank_start), .blank_done(blank_done), .err_led(err_led),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_busy(mem_busy), .err_align(err_align)
  );

  function automatic logic [7:0] patt(int i);
    return 8'((i * 7) + 3);
  endfunction

  // memory model: write strobe starts a busy period, read data one cycle later
  assign mem_busy = (busy_cnt != 0);
  always @(posedge clk) begin
    if (mem_init) begin
      for (int i = 0; i < 4096; i++) bmem[i] <= patt(i);
    end else begin
      if (mem_we) begin
        bmem[mem_addr[11:0]] <= mem_wdata;
        busy_cnt <= busy_len;
      end else if (busy_cnt != 0) begin
        busy_cnt <= busy_cnt - 1;
      end
      if (mem_re) mem_rdata <= bmem[mem_addr[11:0]];
    end
  end

  // monitors
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (mem_we) wcount <= wcount + 1;
      if ((mem_we || mem_re) && mem_busy) we_busy <= we_busy + 1;
      if (rx_valid && rx_ready && mem_busy) overlap <= overlap + 1;
      if (blank_start) blanks <= blanks + 1;
      if (rx_ready || tx_valid) seen_io <= seen_io + 1;
    end
    if (err_led != led_prev) begin
      toggles  <= toggles + 1;
      prev_tog <= last_tog;
      last_tog <= cyc;
    end
    led_prev <= err_led;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_data  = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic take_tx(input logic [7:0] exp, input string req);
    logic [7:0] got;
    while (!tx_valid) @(negedge clk);
    got = tx_data;
    @(negedge clk);
    chk(tx_valid && tx_data == got, "R12 hold", int'(tx_data), int'(got));
    chk(got == exp, req, int'(got), int'(exp));
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic do_reset(input logic m, input logic s);
    rst_n = 1'b0;
    mode_sel = m;
    sec_n = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int nexp;
    int snap_io, snap_bl, snap_tog;
    logic [15:0] a, base;
    int c;
    nexp = 0;
    for (int i = 0; i < 4096; i++) gold[i] = patt(i);
    mem_init = 1'b1;
    @(negedge clk);
    mem_init = 1'b0;
    @(negedge clk);
    // reset state
    chk(!rx_ready && !tx_valid, "R11 reset quiet", int'(rx_ready), 0);
    chk(!mem_we && !mem_re, "R7 reset strobes", int'(mem_we), 0);
    chk(!err_align && !err_led && !blank_start, "R4 reset flags", int'(err_align), 0);

    // expected echoes and golden memory, computed from the requirements
    for (int k = 0; k < NREC; k++) begin
      a = RECS[k][47:32];
      base = a & 16'hFFFC;
      c = 0;
      if (base >= OTP_LO && base <= OTP_HI) c = 1;
      else if (base >= EE_LO && base <= EE_HI) c = 2;
      if (a[1:0] == 2'b00) begin
        if (c == 1) begin
          for (int j = 0; j < 4; j++) gold[base[11:0] + 12'(j)] = RECS[k][31-8*j -: 8];
          nexp += 4;
        end else if (c == 2) begin
          gold[base[11:0]] = RECS[k][31:24];
          nexp += 1;
        end
      end
      exp_echo[k] = {a, gold[base[11:0]], gold[base[11:0] + 12'd1],
                     gold[base[11:0] + 12'd2], gold[base[11:0] + 12'd3]};
    end

    // main run: mode high, security open
    snap_bl = blanks;
    do_reset(1'b1, 1'b1);
    take_tx(8'h00, "R6 prompt first");
    take_tx(8'h00, "R6 prompt second");
    chk(!err_align, "R4 clear before misaligned", int'(err_align), 0);
    for (int k = 0; k < NREC; k++) begin
      for (int p = 0; p < 6; p++) begin
        send_byte(RECS[k][47-8*p -: 8]);
        take_tx((k < 2) ? 8'h00 : exp_echo[k-2][47-8*p -: 8], "R5 echo");
      end
      if (k == 2) chk(!err_align, "R4 aligned no error", int'(err_align), 0);
      if (k == 3) chk(err_align, "R4 misaligned sets", int'(err_align), 1);
    end
    repeat (200) @(negedge clk);
    for (int k = 0; k < NREC; k++) begin
      base = RECS[k][47:32] & 16'hFFFC;
      for (int j = 0; j < 4; j++)
        chk(bmem[base[11:0] + 12'(j)] == gold[base[11:0] + 12'(j)], "R1 R2 R3 memory",
            int'(bmem[base[11:0] + 12'(j)]), int'(gold[base[11:0] + 12'(j)]));
    end
    chk(wcount == nexp, "R1 R2 R3 write count", wcount, nexp);
    chk(we_busy == 0, "R7 strobe while busy", we_busy, 0);
    chk(overlap > 0, "R8 overlap", overlap, 1);
    chk(blanks == snap_bl, "R10 no blank request", blanks - snap_bl, 0);
    chk(!err_led, "R11 led idle when open", int'(err_led), 0);
    chk(err_align, "R4 sticky", int'(err_align), 1);

    // blank-check entry
    snap_bl = blanks;
    do_reset(1'b0, 1'b1);
    snap_io = seen_io;
    repeat (12) @(negedge clk);
    chk(blanks - snap_bl == 1, "R9 one blank pulse", blanks - snap_bl, 1);
    chk(seen_io == snap_io, "R9 quiet before done", seen_io - snap_io, 0);
    blank_done = 1'b1;
    @(negedge clk);
    blank_done = 1'b0;
    take_tx(8'h00, "R9 prompt after blank");
    take_tx(8'h00, "R9 prompt after blank");

    // locked entry
    do_reset(1'b1, 1'b0);
    rx_valid = 1'b1;
    snap_io = seen_io;
    snap_tog = toggles;
    repeat (60) @(negedge clk);
    chk(seen_io == snap_io, "R11 locked quiet", seen_io - snap_io, 0);
    chk(toggles - snap_tog >= 10, "R11 led toggles", toggles - snap_tog, 14);
    chk(last_tog - prev_tog == BLINK, "R11 toggle period", last_tog - prev_tog, BLINK);
    rx_valid = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule